// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Per-Pin Peripheral Overrides

This block is one eight-pin general-purpose I/O port. Software owns three byte registers over a small write-strobed bus: a direction byte, an output byte, and a pin-read location. Software sets direction, drives levels and requests pull-ups through these registers. The block turns them into four pad-control vectors: driver enable, driven level, pull-up enable and input enable.

A peripheral can take over any single control of any single pin. Each control has its own enable/value pair. When the enable is high the value wins, whatever the software registers hold. A further per-pin toggle request inverts the output register bit once per clock cycle. Peripherals get the pad level straight from the pad, without any synchronizer, gated only by the input enable. Software reads the pad level through a two-stage synchronizer.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is low, the direction and output registers are held at zero. With no overrides, every pin is then an undriven input with its pull-up off.
- R2: A bus write to address 0 loads the direction byte, and a write to address 1 loads the output byte, at the next rising clock edge. Reads are combinational: address 0 returns the direction byte, address 1 the output byte, and address 3 returns zero.
- R3: A bus write to address 2 inverts every output-register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: In a cycle with no bus write to address 1 or 2, each output-register bit whose toggle-override input is high inverts at the clock edge. A write to address 1 or 2 takes priority, and all toggle requests are dropped in that cycle.
- R5: A pin's driver enable equals its direction-override value when its direction-override enable is high. Otherwise it equals the direction register bit.
- R6: While a pin's driver is enabled, its driven level is the value-override value if the value-override enable is high, and the output register bit if not. While the driver is off, the driven level is 0.
- R7: With the pull-up override enable low, a pin's pull-up is on exactly when its direction bit is 0, its output bit is 1 and the global pull-up-disable input is 0.
- R8: With the pull-up override enable high, a pin's pull-up equals the pull-up override value, regardless of the registers and the global disable.
- R9: A pin's input enable equals its input-enable override value when that override enable is high. Otherwise it is 1 in normal mode and 0 while the sleep input is high.
- R10: The raw peripheral input of each pin is the pad level ANDed with that pin's input enable, with no register in the path.
- R11: A read of address 2 returns the pad level ANDed with the input enable, passed through two flip-flops. A change is therefore visible after two rising clock edges. Both flip-flops clear on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address (0 direction, 1 output, 2 pin-read/toggle) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pullup_off | input | 1 | Global pull-up disable |
| sleep_mode | input | 1 | Device sleep state; turns input enables off unless overridden |
| ovr_pu_en | input | 8 | Pull-up override enables |
| ovr_pu_val | input | 8 | Pull-up override values |
| ovr_dir_en | input | 8 | Driver-enable override enables |
| ovr_dir_val | input | 8 | Driver-enable override values |
| ovr_lvl_en | input | 8 | Driven-level override enables |
| ovr_lvl_val | input | 8 | Driven-level override values |
| ovr_tgl_en | input | 8 | Per-pin output-bit toggle requests |
| ovr_ie_en | input | 8 | Input-enable override enables |
| ovr_ie_val | input | 8 | Input-enable override values |
| pad_in | input | 8 | Pad levels |
| pad_oe | output | 8 | Pad driver enables |
| pad_out | output | 8 | Pad driven levels |
| pad_pu | output | 8 | Pad pull-up enables |
| pad_ie | output | 8 | Pad digital input enables |
| raw_in | output | 8 | Unsynchronized gated pad input for peripherals |

## Verification
The hardest case to reach from the ports is a toggle request that collides with a bus write to address 1 or 2 in the same cycle while other pins keep toggling. This is the only place where the update priority can be seen. A second hard case is a change of input enable made while the pad level is also moving; it must appear in the readback exactly two edges later. Directed steps set up both collisions on purpose. Random cycles then write often and hold toggle requests for several cycles, and they flip sleep and the input overrides while the pads change. A cycle-level model in the bench predicts the outputs, the register state and the two-stage readback pipeline.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DIR = 2'd0;
  localparam logic [ADDR_W-1:0] A_OUT = 2'd1;
  localparam logic [ADDR_W-1:0] A_PIN = 2'd2;

  // pull-up request from registers alone
  function automatic logic pu_from_regs(input logic dir_b, input logic out_b,
                                        input logic pud);
    return (!dir_b) && out_b && (!pud);
  endfunction

  // generic override selector
  function automatic logic pick(input logic ovr_en, input logic ovr_val,
                                input logic dflt);
    return ovr_en ? ovr_val : dflt;
  endfunction

  // driven level with driver gating
  function automatic logic lvl_gate(input logic oe, input logic lvl);
    return oe & lvl;
  endfunction

endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      tgl_req,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic              out_load,
  output logic              out_flip,
  output logic              tgl_apply
);

  logic dir_load;
  logic [W-1:0] out_next;

  assign dir_load  = wr && (addr == A_DIR);
  assign out_load  = wr && (addr == A_OUT);
  assign out_flip  = wr && (addr == A_PIN);
  assign tgl_apply = !(out_load || out_flip) && (|tgl_req);

  always_comb begin
    if (out_load)       out_next = wdata;
    else if (out_flip)  out_next = out_q ^ wdata;
    else                out_next = out_q ^ tgl_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_load) dir_q <= wdata;
      out_q <= out_next;
    end
  end

endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] out_q,
  input  logic         pullup_off,
  input  logic         sleep_mode,
  input  logic [W-1:0] ovr_pu_en,
  input  logic [W-1:0] ovr_pu_val,
  input  logic [W-1:0] ovr_dir_en,
  input  logic [W-1:0] ovr_dir_val,
  input  logic [W-1:0] ovr_lvl_en,
  input  logic [W-1:0] ovr_lvl_val,
  input  logic [W-1:0] ovr_ie_en,
  input  logic [W-1:0] ovr_ie_val,
  output logic [W-1:0] oe,
  output logic [W-1:0] lvl,
  output logic [W-1:0] pu,
  output logic [W-1:0] ie
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic oe_b;
    assign oe_b   = pick(ovr_dir_en[i], ovr_dir_val[i], dir_q[i]);
    assign oe[i]  = oe_b;
    assign lvl[i] = lvl_gate(oe_b, pick(ovr_lvl_en[i], ovr_lvl_val[i], out_q[i]));
    assign pu[i]  = pick(ovr_pu_en[i], ovr_pu_val[i],
                         pu_from_regs(dir_q[i], out_q[i], pullup_off));
    assign ie[i]  = pick(ovr_ie_en[i], ovr_ie_val[i], !sleep_mode);
  end

endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              pullup_off,
  input  logic              sleep_mode,
  input  logic [W-1:0]      ovr_pu_en,
  input  logic [W-1:0]      ovr_pu_val,
  input  logic [W-1:0]      ovr_dir_en,
  input  logic [W-1:0]      ovr_dir_val,
  input  logic [W-1:0]      ovr_lvl_en,
  input  logic [W-1:0]      ovr_lvl_val,
  input  logic [W-1:0]      ovr_tgl_en,
  input  logic [W-1:0]      ovr_ie_en,
  input  logic [W-1:0]      ovr_ie_val,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu,
  output logic [W-1:0]      pad_ie,
  output logic [W-1:0]      raw_in
);

  logic [W-1:0] dir_q, out_q, pin_sync, gated_in;
  logic         out_load, out_flip, tgl_apply;

  gpio_ovr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tgl_req(ovr_tgl_en), .dir_q(dir_q), .out_q(out_q),
    .out_load(out_load), .out_flip(out_flip), .tgl_apply(tgl_apply)
  );

  gpio_ovr_pinmux #(.W(W)) u_mux (
    .dir_q(dir_q), .out_q(out_q), .pullup_off(pullup_off), .sleep_mode(sleep_mode),
    .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
    .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val),
    .ovr_lvl_en(ovr_lvl_en), .ovr_lvl_val(ovr_lvl_val),
    .ovr_ie_en(ovr_ie_en), .ovr_ie_val(ovr_ie_val),
    .oe(pad_oe), .lvl(pad_out), .pu(pad_pu), .ie(pad_ie)
  );

  assign gated_in = pad_in & pad_ie;
  assign raw_in   = gated_in;

  gpio_ovr_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gated_in), .q(pin_sync)
  );

  always_comb begin
    unique case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_OUT:   bus_rdata = out_q;
      A_PIN:   bus_rdata = pin_sync;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      ovr_tgl_en,
  input logic [W-1:0]      ovr_pu_en,
  input logic [W-1:0]      ovr_dir_en,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_pu,
  input logic [W-1:0]      pad_ie,
  input logic [W-1:0]      out_q,
  input logic [W-1:0]      dir_q,
  input logic              out_load,
  input logic              out_flip
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: reset holds registers clear
  always @(posedge clk) if (!rst_n) a_r1_reset_clear: assert (dir_q == '0 && out_q == '0);

  a_r2_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    out_load |=> out_q == $past(bus_wdata));

  a_r3_pin_flip: assert property (@(posedge clk) disable iff (!rst_n)
    out_flip |=> out_q == ($past(out_q) ^ $past(bus_wdata)));

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_load || out_flip) |=> out_q == ($past(out_q) ^ $past(ovr_tgl_en)));

  // R6: an undriven pad is never driven high
  a_r6_no_lvl_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R7: register-controlled pull-up never coexists with a register-driven pin
  a_r7_pu_vs_driver: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe & ~ovr_pu_en & ~ovr_dir_en) == '0);

  a_r11_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && bus_addr == A_PIN) |-> bus_rdata == $past(pad_in & pad_ie, 2));

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> dir_q == $past(bus_wdata));

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovr_tgl_en(ovr_tgl_en),
  .ovr_pu_en(ovr_pu_en), .ovr_dir_en(ovr_dir_en), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_ie(pad_ie),
  .out_q(out_q), .dir_q(dir_q), .out_load(out_load), .out_flip(out_flip)
);

// File: tb/gpio_ovr_port_test.sv
module gpio_ovr_port_test;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       pullup_off = 0, sleep_mode = 0;
  logic [7:0] ovr_pu_en = 0, ovr_pu_val = 0, ovr_dir_en = 0, ovr_dir_val = 0;
  logic [7:0] ovr_lvl_en = 0, ovr_lvl_val = 0, ovr_tgl_en = 0, ovr_ie_en = 0, ovr_ie_val = 0;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_oe, pad_out, pad_pu, pad_ie, raw_in;

  int total = 0, bad = 0;
  logic done = 0;

  // bench model state
  logic [7:0] m_dir = 0, m_out = 0, m_s1 = 0, m_s2 = 0;

  always #5 clk = ~clk;

  gpio_ovr_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pullup_off(pullup_off),
    .sleep_mode(sleep_mode), .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
    .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val), .ovr_lvl_en(ovr_lvl_en),
    .ovr_lvl_val(ovr_lvl_val), .ovr_tgl_en(ovr_tgl_en), .ovr_ie_en(ovr_ie_en),
    .ovr_ie_val(ovr_ie_val), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_ie(pad_ie), .raw_in(raw_in)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected values written per pin from the requirement text
  function automatic logic [7:0] f_oe();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ovr_dir_en[i] ? ovr_dir_val[i] : m_dir[i];
    return r;
  endfunction

  function automatic logic [7:0] f_lvl();
    logic [7:0] r, oe;
    oe = f_oe();
    for (int i = 0; i < 8; i++)
      r[i] = !oe[i] ? 1'b0 : (ovr_lvl_en[i] ? ovr_lvl_val[i] : m_out[i]);
    return r;
  endfunction

  function automatic logic [7:0] f_pu();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      if (ovr_pu_en[i]) r[i] = ovr_pu_val[i];
      else r[i] = (m_dir[i] == 1'b0) && (m_out[i] == 1'b1) && (pullup_off == 1'b0);
    return r;
  endfunction

  function automatic logic [7:0] f_ie();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ovr_ie_en[i] ? ovr_ie_val[i] : ~sleep_mode;
    return r;
  endfunction

  function automatic logic [7:0] f_rd();
    case (bus_addr)
      2'd0: return m_dir;
      2'd1: return m_out;
      2'd2: return m_s2;
      default: return 8'h00;
    endcase
  endfunction

  // one cycle: inputs already driven after a negedge
  task automatic cycle();
    logic [7:0] n_dir, n_out, n_s1, n_s2;
    #1;
    chk("R5 pad_oe", pad_oe, f_oe());
    chk("R6 pad_out", pad_out, f_lvl());
    chk(ovr_pu_en == 0 ? "R7 pad_pu" : "R8 pad_pu", pad_pu, f_pu());
    chk("R9 pad_ie", pad_ie, f_ie());
    chk("R10 raw_in", raw_in, pad_in & f_ie());
    chk(bus_addr == 2'd2 ? "R11 readback" : "R2 readback", bus_rdata, f_rd());
    n_dir = m_dir; n_out = m_out;
    if (bus_wr && bus_addr == 2'd0) n_dir = bus_wdata;
    if (bus_wr && bus_addr == 2'd1) n_out = bus_wdata;
    else if (bus_wr && bus_addr == 2'd2) n_out = m_out ^ bus_wdata;
    else n_out = m_out ^ ovr_tgl_en;
    n_s1 = pad_in & f_ie();
    n_s2 = m_s1;
    if (!rst_n) begin n_dir = 0; n_out = 0; n_s1 = 0; n_s2 = 0; end
    @(posedge clk);
    m_dir = n_dir; m_out = n_out; m_s1 = n_s1; m_s2 = n_s2;
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; ovr_tgl_en = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset state, even with writes and toggles presented
    bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'hFF; ovr_tgl_en = 8'hFF;
    cycle();
    bus_addr = 2'd0;
    cycle();
    chk("R1 dir after reset", bus_rdata, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    idle();
    rst_n = 1;
    cycle();

    // R2: write direction and output
    bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h0F; cycle();
    bus_addr = 2'd1; bus_wdata = 8'hA5; cycle();
    bus_wr = 0; bus_addr = 2'd1; #1;
    chk("R2 out readback", bus_rdata, 8'hA5);
    bus_addr = 2'd3; #1;
    chk("R2 addr3 zero", bus_rdata, 8'h00);
    // R7: pull-up on inputs with port 1: dir 0F, out A5 -> bits 7,5 on
    chk("R7 pull-up", pad_pu, 8'hA0);
    pullup_off = 1; #1;
    chk("R7 global disable", pad_pu, 8'h00);
    pullup_off = 0;
    cycle();

    // R3: pin-address write flips selected bits
    bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h3C; cycle();
    bus_wr = 0; bus_addr = 2'd1; #1;
    chk("R3 flip", bus_rdata, 8'hA5 ^ 8'h3C);
    cycle();

    // R4: toggle for three cycles, then collide with writes
    ovr_tgl_en = 8'h81; cycle(); cycle(); cycle();
    #1; chk("R4 three toggles", bus_rdata, (8'hA5 ^ 8'h3C) ^ 8'h81);
    bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h55; cycle();
    bus_wr = 0; ovr_tgl_en = 0; #1;
    chk("R4 write beats toggle", bus_rdata, 8'h55);
    ovr_tgl_en = 8'hF0; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h01; cycle();
    bus_wr = 0; ovr_tgl_en = 0; bus_addr = 2'd1; #1;
    chk("R4 pin write beats toggle", bus_rdata, 8'h54);
    cycle();

    // R8/R9/R11 directed: overrides, sleep, readback delay
    ovr_pu_en = 8'hFF; ovr_pu_val = 8'h5A; pullup_off = 1; #1;
    chk("R8 override", pad_pu, 8'h5A);
    ovr_pu_en = 0; pullup_off = 0;
    pad_in = 8'hC3; bus_addr = 2'd2; sleep_mode = 1; ovr_ie_en = 8'h03; ovr_ie_val = 8'h01;
    cycle(); cycle();
    #1; chk("R11 gated by ie", bus_rdata, 8'h01);
    chk("R9 sleep", pad_ie, 8'h01);
    sleep_mode = 0; ovr_ie_en = 0;
    cycle();
    #1; chk("R11 one edge not yet", bus_rdata, 8'h01);
    cycle();
    #1; chk("R11 two edges", bus_rdata, 8'hC3);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bus_wr      = ($urandom % 3) == 0;
      bus_addr    = 2'($urandom);
      bus_wdata   = 8'($urandom);
      pullup_off  = ($urandom % 4) == 0;
      sleep_mode  = ($urandom % 5) == 0;
      ovr_pu_en   = 8'($urandom & $urandom); ovr_pu_val  = 8'($urandom);
      ovr_dir_en  = 8'($urandom & $urandom); ovr_dir_val = 8'($urandom);
      ovr_lvl_en  = 8'($urandom);            ovr_lvl_val = 8'($urandom);
      if (n % 4 == 0) ovr_tgl_en = 8'($urandom & $urandom);
      ovr_ie_en   = 8'($urandom & $urandom); ovr_ie_val  = 8'($urandom);
      pad_in      = 8'($urandom);
      cycle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule